// File: doc/BRIEF.md
# SIMD Lane Min/Max and Predicate Compare Unit

This block takes two wide vector operands and treats them as a row of equal-width lanes of 8, 16 or 32 bits. It does one of two kinds of work on each accepted beat. A select operation (min or max, signed or unsigned) produces a vector of the same width. A relational operation (equal, not-equal, less-than, less-or-equal, signed or unsigned) produces a fixed 64-bit predicate mask. In that mask every lane owns a field of 64 / lane-count bits. The field is all ones when the relation holds and all zeros when it does not. Greater-than and greater-or-equal come from the less-than and less-or-equal codes with the operand-swap control set.

Signed ordering maps onto one unsigned comparator per lane. The comparator inverts each lane's top bit before comparing. Results sit in output registers, one per kind of result. A beat changes only the register that belongs to its kind of operation. The other register keeps its previous contents.

Operands enter on a valid/ready handshake. A beat is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty or when the consumer takes the current result in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the outputs hold their values and no new beat is taken. The operation fields are sampled only with an accepted beat.

Top module: `vec_minmax_cmp`

## Requirements
- R1: `in_width` selects the lane width: 0 = 8-bit (64 lanes), 1 = 16-bit (32 lanes), 2 = 32-bit (16 lanes). Code 3 behaves exactly like code 2.
- R2: For a compare, lane i writes `out_mask[i*k +: k]`, where k = 64 / lane count (1, 2 or 4). The field is all ones if the relation holds and all zeros otherwise, and the fields cover all 64 bits.
- R3: Signed less-than and less-or-equal order the lanes as two's complement, and unsigned ones order them as plain binary. With 16-bit lanes, 0x8000 < 0x0001 is true when signed and false when unsigned, and 0x0001 < 0xFFFF is true when unsigned.
- R4: Equal (code 2) and not-equal (code 3) give the same result whatever `in_signed` is.
- R5: With `in_swap` = 1 the two operands trade places before any operation, so less-than gives greater-than and less-or-equal gives greater-or-equal.
- R6: Min (code 0) returns the first operand when it is ≤ the second under the chosen signedness, and otherwise the second. Max (code 1) returns the larger one. Example: signed min(0x8000, 0x0001) = 0x8000 and unsigned min = 0x0001.
- R7: A compare beat (codes 2, 3, 4 = less-than, 5 = less-or-equal) leaves `out_vec` unchanged.
- R8: A min/max beat leaves `out_mask` unchanged. Codes 6 and 7 change neither output but still raise `out_valid`.
- R9: The result of a beat accepted at a rising edge is on the outputs after that edge with `out_valid` high. `out_valid` falls after an edge where `out_ready` is high and no beat is taken.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_vec`, `out_mask` and `out_valid` hold.
- R11: A synchronous active-high `rst` clears `out_vec`, `out_mask` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_a | input | VEC_W | First operand vector |
| in_b | input | VEC_W | Second operand vector |
| in_width | input | 2 | Lane width code |
| in_op | input | 3 | Operation code (0 min, 1 max, 2 eq, 3 neq, 4 lt, 5 le) |
| in_signed | input | 1 | 1 = signed ordering |
| in_swap | input | 1 | 1 = exchange the operands |
| out_valid | output | 1 | Result registers hold an unconsumed result |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | VEC_W | Min/max result vector |
| out_mask | output | MASK_W | Compare predicate mask |

## Verification
The assertions check the handshake and register-ownership rules on every cycle. Outputs hold under back-pressure, a taken beat raises `out_valid`, a drained result clears it, a compare never disturbs `out_vec`, and a min/max never disturbs `out_mask`. They also check that every mask field written by a 16- or 32-bit compare is uniform. Lane values can only be shown by the bench's reference model and its scenarios. These include signed against unsigned ordering at the 0x8000 boundary, swapped operands, field placement for a single true lane at each width, and the reserved width code.

// File: rtl/vec_minmax_cmp_pkg.sv
package vec_minmax_cmp_pkg;

  typedef enum logic [1:0] {
    LW_8   = 2'd0,
    LW_16  = 2'd1,
    LW_32  = 2'd2,
    LW_32R = 2'd3
  } lane_w_e;

  typedef enum logic [2:0] {
    OP_MIN  = 3'd0,
    OP_MAX  = 3'd1,
    OP_EQ   = 3'd2,
    OP_NE   = 3'd3,
    OP_LT   = 3'd4,
    OP_LE   = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  function automatic logic op_is_select(op_e op);
    return (op == OP_MIN) || (op == OP_MAX);
  endfunction

  function automatic logic op_is_compare(op_e op);
    return (op == OP_EQ) || (op == OP_NE) || (op == OP_LT) || (op == OP_LE);
  endfunction

  function automatic logic rel_hit(op_e op, logic lt, logic eq);
    logic h;
    case (op)
      OP_EQ:   h = eq;
      OP_NE:   h = ~eq;
      OP_LT:   h = lt;
      OP_LE:   h = lt | eq;
      default: h = 1'b0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/vec_lane_order.sv
// Orders one lane pair: flips the top bit for signed ordering so a single
// unsigned comparator serves both signednesses.
module vec_lane_order #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] x,
  input  logic [LANE_W-1:0] y,
  input  logic              sgn,
  output logic              lt,
  output logic              eq
);
  logic [LANE_W-1:0] xb, yb;

  assign xb = {x[LANE_W-1] ^ sgn, x[LANE_W-2:0]};
  assign yb = {y[LANE_W-1] ^ sgn, y[LANE_W-2:0]};
  assign lt = xb < yb;
  assign eq = x == y;
endmodule

// File: rtl/vec_lane_bank.sv
// One lane geometry: splits both operands into LANE_W lanes, produces the
// select vector and the predicate mask for that geometry.
module vec_lane_bank
  import vec_minmax_cmp_pkg::*;
#(
  parameter int VEC_W  = 512,
  parameter int MASK_W = 64,
  parameter int LANE_W = 16
) (
  input  logic [VEC_W-1:0]  x,
  input  logic [VEC_W-1:0]  y,
  input  logic              sgn,
  input  op_e               op,
  output logic [VEC_W-1:0]  sel_vec,
  output logic [MASK_W-1:0] mask
);
  localparam int LANES = VEC_W / LANE_W;
  localparam int FLD_W = MASK_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] xl, yl;
    logic lt, eq, hit;

    assign xl = x[g*LANE_W +: LANE_W];
    assign yl = y[g*LANE_W +: LANE_W];

    vec_lane_order #(.LANE_W(LANE_W)) u_ord (
      .x  (xl),
      .y  (yl),
      .sgn(sgn),
      .lt (lt),
      .eq (eq)
    );

    assign hit = rel_hit(op, lt, eq);
    assign mask[g*FLD_W +: FLD_W] = {FLD_W{hit}};
    assign sel_vec[g*LANE_W +: LANE_W] = (op == OP_MAX) ? (lt ? yl : xl)
                                                        : ((lt | eq) ? xl : yl);
  end
endmodule

// File: rtl/vec_result_stage.sv
// Output registers with a one-entry valid/ready stage; each result register
// is written only when its update enable accompanies an accepted beat.
module vec_result_stage #(
  parameter int VEC_W  = 512,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              upd_vec,
  input  logic              upd_mask,
  input  logic [VEC_W-1:0]  nxt_vec,
  input  logic [MASK_W-1:0] nxt_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_vec,
  output logic [MASK_W-1:0] out_mask
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      out_mask  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        if (upd_vec)  out_vec  <= nxt_vec;
        if (upd_mask) out_mask <= nxt_mask;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vec_minmax_cmp.sv
module vec_minmax_cmp
  import vec_minmax_cmp_pkg::*;
#(
  parameter int VEC_W      = 512,
  parameter int MASK_W     = 64,
  parameter int MIN_LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  in_a,
  input  logic [VEC_W-1:0]  in_b,
  input  logic [1:0]        in_width,
  input  logic [2:0]        in_op,
  input  logic              in_signed,
  input  logic              in_swap,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_vec,
  output logic [MASK_W-1:0] out_mask
);
  localparam int NUM_GEOM = 3;

  op_e               op_d;
  logic [VEC_W-1:0]  opx, opy;
  logic [VEC_W-1:0]  bank_vec  [NUM_GEOM];
  logic [MASK_W-1:0] bank_mask [NUM_GEOM];
  logic [VEC_W-1:0]  nxt_vec;
  logic [MASK_W-1:0] nxt_mask;

  assign op_d = op_e'(in_op);
  assign opx  = in_swap ? in_b : in_a;
  assign opy  = in_swap ? in_a : in_b;

  for (genvar gi = 0; gi < NUM_GEOM; gi++) begin : g_geom
    vec_lane_bank #(
      .VEC_W (VEC_W),
      .MASK_W(MASK_W),
      .LANE_W(MIN_LANE_W << gi)
    ) u_bank (
      .x      (opx),
      .y      (opy),
      .sgn    (in_signed),
      .op     (op_d),
      .sel_vec(bank_vec[gi]),
      .mask   (bank_mask[gi])
    );
  end

  always_comb begin
    case (lane_w_e'(in_width))
      LW_8: begin
        nxt_vec  = bank_vec[0];
        nxt_mask = bank_mask[0];
      end
      LW_16: begin
        nxt_vec  = bank_vec[1];
        nxt_mask = bank_mask[1];
      end
      default: begin
        nxt_vec  = bank_vec[2];
        nxt_mask = bank_mask[2];
      end
    endcase
  end

  vec_result_stage #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .upd_vec  (op_is_select(op_d)),
    .upd_mask (op_is_compare(op_d)),
    .nxt_vec  (nxt_vec),
    .nxt_mask (nxt_mask),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_vec  (out_vec),
    .out_mask (out_mask)
  );
endmodule

// File: rtl/vec_minmax_cmp_chk.sv
module vec_minmax_cmp_chk #(
  parameter int VEC_W  = 512,
  parameter int MASK_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_width,
  input logic [2:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VEC_W-1:0]  out_vec,
  input logic [MASK_W-1:0] out_mask
);
  logic take, is_cmp, is_sel, f16_ok, f32_ok;

  assign take   = in_valid & in_ready;
  assign is_cmp = (in_op >= 3'd2) && (in_op <= 3'd5);
  assign is_sel = in_op < 3'd2;

  always_comb begin
    f16_ok = 1'b1;
    for (int i = 0; i < MASK_W/2; i++)
      if (out_mask[2*i] != out_mask[2*i+1]) f16_ok = 1'b0;
    f32_ok = 1'b1;
    for (int i = 0; i < MASK_W/4; i++)
      if (out_mask[4*i +: 4] != 4'h0 && out_mask[4*i +: 4] != 4'hF) f32_ok = 1'b0;
  end

  a_r10_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_vec) && $stable(out_mask));

  a_r9_valid_after_take: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  a_r9_drain_clears: assert property (@(posedge clk) disable iff (rst)
    !take && out_ready |=> !out_valid);

  a_r7_cmp_keeps_vec: assert property (@(posedge clk) disable iff (rst)
    take && is_cmp |=> $stable(out_vec));

  a_r8_sel_keeps_mask: assert property (@(posedge clk) disable iff (rst)
    take && is_sel |=> $stable(out_mask));

  a_r2_fields16_uniform: assert property (@(posedge clk) disable iff (rst)
    take && is_cmp && in_width == 2'd1 |=> f16_ok);

  a_r2_fields32_uniform: assert property (@(posedge clk) disable iff (rst)
    take && is_cmp && in_width[1] |=> f32_ok);
endmodule

bind vec_minmax_cmp vec_minmax_cmp_chk #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_width (in_width),
  .in_op    (in_op),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_vec  (out_vec),
  .out_mask (out_mask)
);

// File: tb/vec_minmax_cmp_bench.sv
module vec_minmax_cmp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 512;
  localparam int MW = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_ready, in_signed, in_swap, out_valid, out_ready;
  logic [VW-1:0] in_a, in_b, out_vec;
  logic [1:0]    in_width;
  logic [2:0]    in_op;
  logic [MW-1:0] out_mask;

  int n_checks = 0;
  int n_bad    = 0;

  // reference model state
  logic [VW-1:0] m_vec;
  logic [MW-1:0] m_mask;
  logic          m_valid;
  string         vec_tag, mask_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_minmax_cmp u_vec_minmax_cmp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_width(in_width), .in_op(in_op),
    .in_signed(in_signed), .in_swap(in_swap), .out_valid(out_valid),
    .out_ready(out_ready), .out_vec(out_vec), .out_mask(out_mask)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] fill(int w, longint val);
    logic [VW-1:0] r = '0;
    for (int i = 0; i < VW / w; i++)
      r = r | ({{(VW-64){1'b0}}, val & ((longint'(1) << w) - 1)} << (i * w));
    return r;
  endfunction

  // behavioural lane model: integers per lane, no structure shared with the RTL
  task automatic ref_apply(logic [VW-1:0] a, logic [VW-1:0] b, int wsel, int op,
                           bit sgn, bit swp);
    int w, lanes, k;
    logic [VW-1:0] x, y, t;
    w = (wsel == 0) ? 8 : (wsel == 1) ? 16 : 32;
    lanes = VW / w;
    k = MW / lanes;
    x = swp ? b : a;
    y = swp ? a : b;
    for (int i = 0; i < lanes; i++) begin
      longint xu, yu, xs, ys, pick;
      bit lt, eq, rel;
      t  = x >> (i * w);
      xu = longint'(t[31:0]) & ((longint'(1) << w) - 1);
      t  = y >> (i * w);
      yu = longint'(t[31:0]) & ((longint'(1) << w) - 1);
      xs = (xu >= (longint'(1) << (w - 1))) ? xu - (longint'(1) << w) : xu;
      ys = (yu >= (longint'(1) << (w - 1))) ? yu - (longint'(1) << w) : yu;
      lt = sgn ? (xs < ys) : (xu < yu);
      eq = (xu == yu);
      rel = (op == 2) ? eq : (op == 3) ? !eq : (op == 4) ? lt : (lt || eq);
      if (op >= 2 && op <= 5)
        for (int j = 0; j < k; j++) m_mask[i*k + j] = rel;
      if (op <= 1) begin
        pick = (op == 0) ? ((lt || eq) ? xu : yu) : (lt ? yu : xu);
        for (int j = 0; j < w; j++) m_vec[i*w + j] = pick[j];
      end
    end
    vec_tag  = (op <= 1) ? "R6" : (op <= 5) ? "R7" : "R8";
    mask_tag = (op <= 1) ? "R8" : (op <= 5) ? "R2" : "R8";
  endtask

  // inputs already driven at a falling edge; advance one cycle and compare
  task automatic tick();
    logic exp_rdy;
    #1;
    exp_rdy = !m_valid || out_ready;
    if (!rst) chk("R10 in_ready", {511'd0, in_ready}, {511'd0, exp_rdy});
    if (rst) begin
      m_vec = '0; m_mask = '0; m_valid = 1'b0;
    end else if (in_valid && exp_rdy) begin
      m_valid = 1'b1;
      ref_apply(in_a, in_b, in_width, in_op, in_signed, in_swap);
    end else if (out_ready) begin
      m_valid = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R9 out_valid", {511'd0, out_valid}, {511'd0, m_valid});
    chk({vec_tag, " out_vec"}, out_vec, m_vec);
    chk({mask_tag, " out_mask"}, {448'd0, out_mask}, {448'd0, m_mask});
  endtask

  task automatic drive(logic [VW-1:0] a, logic [VW-1:0] b, int w, int op,
                       bit sgn, bit swp, bit vld, bit rdy);
    in_a = a; in_b = b; in_width = w[1:0]; in_op = op[2:0];
    in_signed = sgn; in_swap = swp; in_valid = vld; out_ready = rdy;
  endtask

  task automatic beat(logic [VW-1:0] a, logic [VW-1:0] b, int w, int op, bit sgn, bit swp);
    drive(a, b, w, op, sgn, swp, 1'b1, 1'b1);
    tick();
  endtask

  initial begin
    logic [VW-1:0] hold_v;
    logic [MW-1:0] hold_m;
    logic [VW-1:0] b32;
    vec_tag = "R11"; mask_tag = "R11";
    m_vec = '0; m_mask = '0; m_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    drive('0, '0, 0, 0, 0, 0, 0, 1);
    tick(); tick();
    chk("R11 reset vec", out_vec, '0);
    chk("R11 reset mask", {448'd0, out_mask}, '0);
    chk("R11 reset valid", {511'd0, out_valid}, '0);
    rst = 1'b0;

    // R6 min / max, signed vs unsigned
    beat(fill(16, 'h8000), fill(16, 'h0001), 1, 0, 1, 0);
    chk("R6 signed min", out_vec, fill(16, 'h8000));
    beat(fill(16, 'h8000), fill(16, 'h0001), 1, 0, 0, 0);
    chk("R6 unsigned min", out_vec, fill(16, 'h0001));
    beat(fill(16, 'h8000), fill(16, 'h0001), 1, 1, 1, 0);
    chk("R6 signed max", out_vec, fill(16, 'h0001));
    beat(fill(16, 'h8000), fill(16, 'h0001), 1, 1, 0, 0);
    chk("R6 unsigned max", out_vec, fill(16, 'h8000));

    // R3 signed/unsigned less-than; R7 compare keeps vector
    beat(fill(16, 'h8000), fill(16, 'h0001), 1, 4, 1, 0);
    chk("R3 signed lt", {448'd0, out_mask}, {448'd0, 64'hFFFF_FFFF_FFFF_FFFF});
    chk("R7 vec kept", out_vec, fill(16, 'h8000));
    beat(fill(16, 'h8000), fill(16, 'h0001), 1, 4, 0, 0);
    chk("R3 unsigned lt", {448'd0, out_mask}, '0);
    beat(fill(16, 'h0001), fill(16, 'hFFFF), 1, 4, 0, 0);
    chk("R3 unsigned ltu 1<FFFF", {448'd0, out_mask}, {448'd0, 64'hFFFF_FFFF_FFFF_FFFF});

    // R4 equality ignores signedness
    beat(fill(16, 'h8000), fill(16, 'h8000), 1, 2, 1, 0);
    chk("R4 eq signed", {448'd0, out_mask}, {448'd0, 64'hFFFF_FFFF_FFFF_FFFF});
    beat(fill(16, 'h8000), fill(16, 'h8000), 1, 2, 0, 0);
    chk("R4 eq unsigned", {448'd0, out_mask}, {448'd0, 64'hFFFF_FFFF_FFFF_FFFF});
    beat(fill(16, 'h8000), fill(16, 'h8000), 1, 3, 1, 0);
    chk("R4 neq", {448'd0, out_mask}, '0);

    // R5 swap yields gt / ge
    beat(fill(16, 5), fill(16, 3), 1, 4, 1, 1);
    chk("R5 gt true", {448'd0, out_mask}, {448'd0, 64'hFFFF_FFFF_FFFF_FFFF});
    beat(fill(16, 3), fill(16, 5), 1, 4, 1, 1);
    chk("R5 gt false", {448'd0, out_mask}, '0);
    beat(fill(16, 3), fill(16, 3), 1, 5, 1, 1);
    chk("R5 ge equal", {448'd0, out_mask}, {448'd0, 64'hFFFF_FFFF_FFFF_FFFF});

    // R2 field placement, R1 width codes
    beat({511'd0, 1'b1}, '0, 0, 2, 0, 0);
    chk("R2 8-bit lane0 false", {448'd0, out_mask}, {448'd0, 64'hFFFF_FFFF_FFFF_FFFE});
    b32 = '0; b32[96] = 1'b1;
    beat('0, b32, 2, 4, 0, 0);
    chk("R2 32-bit lane3 true", {448'd0, out_mask}, {448'd0, 64'h0000_0000_0000_F000});
    beat('0, b32, 3, 4, 0, 0);
    chk("R1 code3 as 32-bit", {448'd0, out_mask}, {448'd0, 64'h0000_0000_0000_F000});
    beat('0, b32, 1, 4, 0, 0);
    chk("R1 16-bit lane6", {448'd0, out_mask}, {448'd0, 64'h0000_0000_0000_3000});

    // R8 min keeps mask; reserved codes keep both
    beat(fill(8, 'h7F), fill(8, 'h80), 0, 0, 1, 0);
    chk("R8 min keeps mask", {448'd0, out_mask}, {448'd0, 64'h0000_0000_0000_3000});
    chk("R6 8-bit signed min", out_vec, fill(8, 'h80));
    hold_v = out_vec; hold_m = out_mask;
    beat(fill(8, 1), fill(8, 2), 0, 6, 0, 0);
    chk("R8 op6 vec", out_vec, hold_v);
    chk("R8 op6 mask", {448'd0, out_mask}, {448'd0, hold_m});
    chk("R8 op6 valid", {511'd0, out_valid}, {511'd0, 1'b1});
    beat(fill(8, 1), fill(8, 2), 0, 7, 0, 0);
    chk("R8 op7 mask", {448'd0, out_mask}, {448'd0, hold_m});

    // R10 back-pressure, R9 drain
    drive(fill(32, 9), fill(32, 4), 2, 1, 0, 0, 1, 0);
    tick();
    chk("R10 stall vec", out_vec, hold_v);
    chk("R10 stall ready", {511'd0, in_ready}, '0);
    tick();
    chk("R10 stall valid", {511'd0, out_valid}, {511'd0, 1'b1});
    out_ready = 1'b1;
    tick();
    chk("R9 taken after release", out_vec, fill(32, 9));
    drive('0, '0, 0, 0, 0, 0, 0, 1);
    tick();
    chk("R9 drained", {511'd0, out_valid}, '0);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [VW-1:0] ra, rb;
      for (int q = 0; q < VW / 32; q++) begin
        ra[q*32 +: 32] = $urandom;
        rb[q*32 +: 32] = ($urandom_range(0, 1) == 0) ? ra[q*32 +: 32] ^ (32'h1 << $urandom_range(0, 31))
                                                       : $urandom;
        if ($urandom_range(0, 3) == 0) rb[q*32 +: 32] = ra[q*32 +: 32];
      end
      drive(ra, rb, $urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0);
      tick();
    end

    finish_run();
  end
endmodule